// File: doc/BRIEF.md
# Popcount-Compacted Signature Register

This block gathers a self-test signature from wide words taken off the operand crossbar. Every valid word is first reduced to its population count. That count is folded into a 16-bit multiple-input shift register. After many such samples, the sequencer issues a check request. The block then compares the accumulated value with a golden constant and raises a one-cycle done pulse together with a match flag. A match lets the core proceed to boot.

The signature is also a crossbar endpoint in both directions. It is always presented on `sig_o`, so it can be read as crossbar write data. A load strobe writes the low bits of the crossbar word straight into the register.

A three-state controller governs the block:
- `ST_ACCUM` collects samples. `check_i` moves it to `ST_VERDICT`.
- `ST_VERDICT` lasts one cycle and shows the done pulse. It always moves on to `ST_HELD`.
- `ST_HELD` freezes the result until a clear.

A clear, or reset, returns any state to `ST_ACCUM`.

Top module: `sig_compactor`

## Requirements
- R1: Reset (synchronous, `rst_ni` low) and `clear_i` both load the seed 0xFFFF, drive `match_o` and `done_o` low and enter `ST_ACCUM`. Clear is honoured in every state.
- R2: In `ST_ACCUM`, a valid sample updates the signature to step(sig ^ pc) one cycle later. Here pc is the number of ones in `data_i`, zero-extended into the low bits.
- R3: step(t) shifts t left by one, dropping bit 15 and inserting a 0 at bit 0. If the dropped bit was 1, the result is XORed with 0x1021 (polynomial x^16+x^12+x^5+1). With no strobe asserted, the signature holds its value.
- R4: In `ST_ACCUM`, `load_i` writes `data_i[15:0]` into the signature on the next edge.
- R5: `check_i` in `ST_ACCUM` compares the current signature, before any update, with GOLDEN. `done_o` is high for exactly the one following cycle, with `match_o` set to the result.
- R6: After a check, `match_o` and the signature stay frozen until a clear. `valid_i`, `load_i` and `check_i` have no effect during that time.
- R7: Within one cycle the priority is clear, then check, then load, then valid. A strobe that loses has no effect.
- R8: `sig_o` presents the signature register on every cycle, for use as crossbar write data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Synchronous active-low reset |
| data_i | input | 64 | Word sampled from the crossbar |
| valid_i | input | 1 | Sample strobe |
| load_i | input | 1 | Write data_i[15:0] into the signature |
| clear_i | input | 1 | Reload the seed and restart |
| check_i | input | 1 | Compare against GOLDEN |
| sig_o | output | 16 | Current signature (crossbar write data) |
| match_o | output | 1 | Comparison result, valid after done |
| done_o | output | 1 | One-cycle verdict pulse |
| state_o | output | 2 | Controller state (0 accum, 1 verdict, 2 held) |

## Verification
The assertions assume the inputs are known, 0 or 1, on every clock edge while reset is released. They also assume reset is held for at least one edge before any strobe. They place no restriction on strobes overlapping, so the priority and freezing properties must hold under any mix.

The stimulus drives every input to a defined value away from the clock edge. It deliberately combines strobes in the same cycle, and keeps applying strobes in the verdict and held states, so those properties are exercised. Sampled words include all-zero, all-one, alternating and random patterns, so the full popcount range reaches the shift register.

// File: rtl/sig_compactor_pkg.sv
package sig_compactor_pkg;
    typedef enum logic [1:0] {
        ST_ACCUM   = 2'd0,
        ST_VERDICT = 2'd1,
        ST_HELD    = 2'd2
    } ctl_state_e;
endpackage

// File: rtl/ones_counter.sv
module ones_counter #(
    parameter int DATA_W = 64,
    localparam int CNT_W = $clog2(DATA_W + 1)
) (
    input  logic [DATA_W-1:0] word_i,
    output logic [CNT_W-1:0]  count_o
);
    always_comb begin
        count_o = '0;
        for (int i = 0; i < DATA_W; i++) begin
            count_o = count_o + CNT_W'(word_i[i]);
        end
    end
endmodule

// File: rtl/sig_shift_reg.sv
module sig_shift_reg #(
    parameter int          SIG_W = 16,
    parameter int          CNT_W = 7,
    parameter logic [15:0] POLY  = 16'h1021,
    parameter logic [15:0] SEED  = 16'hFFFF
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             clr_i,
    input  logic             ld_i,
    input  logic             upd_i,
    input  logic [SIG_W-1:0] ld_val_i,
    input  logic [CNT_W-1:0] count_i,
    output logic [SIG_W-1:0] sig_o
);
    logic [SIG_W-1:0] sig_q, mixed, shifted;

    always_comb begin
        mixed   = sig_q ^ {{(SIG_W-CNT_W){1'b0}}, count_i};
        shifted = {mixed[SIG_W-2:0], 1'b0};
        if (mixed[SIG_W-1]) shifted = shifted ^ POLY[SIG_W-1:0];
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni || clr_i) sig_q <= SEED[SIG_W-1:0];
        else if (ld_i)        sig_q <= ld_val_i;
        else if (upd_i)       sig_q <= shifted;
    end

    assign sig_o = sig_q;
endmodule

// File: rtl/sig_ctrl.sv
module sig_ctrl
    import sig_compactor_pkg::*;
(
    input  logic       clk_i,
    input  logic       rst_ni,
    input  logic       clear_i,
    input  logic       check_i,
    input  logic       load_i,
    input  logic       valid_i,
    input  logic       sig_eq_i,
    output logic       ld_o,
    output logic       upd_o,
    output logic       done_o,
    output logic       match_o,
    output ctl_state_e state_o
);
    ctl_state_e state_q, state_d;
    logic       match_q;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_ACCUM:   if (check_i) state_d = ST_VERDICT;
            ST_VERDICT: state_d = ST_HELD;
            ST_HELD:    state_d = ST_HELD;
            default:    state_d = ST_ACCUM;
        endcase
        if (clear_i) state_d = ST_ACCUM;
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            state_q <= ST_ACCUM;
            match_q <= 1'b0;
        end else begin
            state_q <= state_d;
            if (clear_i)                              match_q <= 1'b0;
            else if (state_q == ST_ACCUM && check_i)  match_q <= sig_eq_i;
        end
    end

    always_comb begin
        ld_o   = 1'b0;
        upd_o  = 1'b0;
        done_o = 1'b0;
        unique case (state_q)
            ST_ACCUM: begin
                ld_o  = !clear_i && !check_i && load_i;
                upd_o = !clear_i && !check_i && !load_i && valid_i;
            end
            ST_VERDICT: done_o = 1'b1;
            ST_HELD:    done_o = 1'b0;
            default:    done_o = 1'b0;
        endcase
    end

    assign match_o = match_q;
    assign state_o = state_q;

    assert_done_single_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |=> !done_o);
    assert_no_match_while_accum_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_q == ST_ACCUM) |-> !match_o);
    assert_match_frozen_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_q != ST_ACCUM && !clear_i) |=> $stable(match_o));
endmodule

// File: rtl/sig_compactor.sv
module sig_compactor
    import sig_compactor_pkg::*;
#(
    parameter int          DATA_W = 64,
    parameter int          SIG_W  = 16,
    parameter logic [15:0] POLY   = 16'h1021,
    parameter logic [15:0] SEED   = 16'hFFFF,
    parameter logic [15:0] GOLDEN = 16'h5A3C
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic [DATA_W-1:0] data_i,
    input  logic              valid_i,
    input  logic              load_i,
    input  logic              clear_i,
    input  logic              check_i,
    output logic [SIG_W-1:0]  sig_o,
    output logic              match_o,
    output logic              done_o,
    output logic [1:0]        state_o
);
    localparam int CNT_W = $clog2(DATA_W + 1);

    logic [CNT_W-1:0] count;
    logic             ld, upd;
    ctl_state_e       state;

    ones_counter #(.DATA_W(DATA_W)) u_count (
        .word_i (data_i),
        .count_o(count)
    );

    sig_shift_reg #(.SIG_W(SIG_W), .CNT_W(CNT_W), .POLY(POLY), .SEED(SEED)) u_sig (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .clr_i   (clear_i),
        .ld_i    (ld),
        .upd_i   (upd),
        .ld_val_i(data_i[SIG_W-1:0]),
        .count_i (count),
        .sig_o   (sig_o)
    );

    sig_ctrl u_ctrl (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .clear_i (clear_i),
        .check_i (check_i),
        .load_i  (load_i),
        .valid_i (valid_i),
        .sig_eq_i(sig_o == GOLDEN[SIG_W-1:0]),
        .ld_o    (ld),
        .upd_o   (upd),
        .done_o  (done_o),
        .match_o (match_o),
        .state_o (state)
    );

    assign state_o = state;

    assert_clear_seeds_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        clear_i |=> (sig_o == SEED[SIG_W-1:0] && !match_o && !done_o));
    assert_idle_holds_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!clear_i && !check_i && !load_i && !valid_i) |=> $stable(sig_o));
    assert_check_gives_done_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state == ST_ACCUM && check_i && !clear_i) |=> done_o);
    assert_sig_frozen_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ((state != ST_ACCUM || check_i) && !clear_i) |=> $stable(sig_o));
endmodule

// File: tb/sig_compactor_tb.sv
module sig_compactor_tb;
    localparam logic [15:0] GOLD = 16'h5A3C;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [63:0] data = '0;
    logic        valid = 1'b0, load = 1'b0, clear = 1'b0, check = 1'b0;
    logic [15:0] sig;
    logic        match, done;
    logic [1:0]  st;

    int n_chk = 0, n_bad = 0;
    int m_sig = 16'hFFFF, m_state = 0;
    bit m_match = 0, m_done = 0;

    always #10 clk = ~clk;

    sig_compactor #(.GOLDEN(GOLD)) u_dut (
        .clk_i(clk), .rst_ni(rst_n), .data_i(data), .valid_i(valid),
        .load_i(load), .clear_i(clear), .check_i(check),
        .sig_o(sig), .match_o(match), .done_o(done), .state_o(st)
    );

    function automatic int mstep(int s, int pc);
        int t = (s ^ pc) << 1;
        if ((t & 32'h10000) != 0) t = t ^ 32'h11021;
        return t & 32'hFFFF;
    endfunction

    task automatic cyc(input bit c, input bit k, input bit l, input bit v,
                       input logic [63:0] d, input string tag);
        clear = c; check = k; load = l; valid = v; data = d;
        @(posedge clk);
        m_done = 0;
        if (!rst_n || c) begin
            m_sig = 16'hFFFF; m_match = 0; m_state = 0;
        end else if (m_state == 0) begin
            if (k) begin
                m_match = (m_sig == GOLD); m_state = 1; m_done = 1;
            end else if (l) m_sig = int'(d[15:0]);
            else if (v)     m_sig = mstep(m_sig, $countones(d));
        end else m_state = 2;
        #5;
        n_chk++;
        if (sig !== 16'(m_sig) || match !== m_match || done !== m_done) begin
            n_bad++;
            $display("FAIL %s: sig=%h match=%b done=%b expected sig=%h match=%b done=%b",
                     tag, sig, match, done, 16'(m_sig), m_match, m_done);
        end
    endtask

    initial begin
        #(20 * 200000);
        n_bad++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        @(negedge clk);
        cyc(0, 0, 0, 0, '0, "R1 reset");
        cyc(1, 1, 1, 1, '1, "R1 reset dominates");
        rst_n = 1'b1;
        cyc(0, 0, 0, 0, '0, "R3 idle hold");
        // R2 popcount folding with distinct patterns
        cyc(0, 0, 0, 1, 64'h0, "R2 zero word");
        cyc(0, 0, 0, 1, '1, "R2 all ones");
        cyc(0, 0, 0, 1, 64'hAAAA_AAAA_AAAA_AAAA, "R2 alternating");
        cyc(0, 0, 0, 1, 64'h8000_0000_0000_0001, "R2 sparse");
        for (int i = 0; i < 60; i++)
            cyc(0, 0, 0, 1, {$urandom, $urandom}, "R2 R8 random sample");
        for (int i = 0; i < 4; i++) cyc(0, 0, 0, 0, {$urandom, $urandom}, "R3 hold without valid");
        cyc(0, 0, 1, 0, 64'h1234_5678_9ABC_8001, "R4 load");
        cyc(0, 0, 1, 1, 64'hFFFF_FFFF_FFFF_4321, "R7 load beats valid");
        cyc(0, 0, 0, 1, 64'h0F0F, "R3 step after load");
        // R5 mismatching check, then R6 freeze
        cyc(0, 1, 1, 1, '1, "R5 R7 check beats load and valid");
        cyc(0, 0, 1, 1, '1, "R6 strobes ignored in verdict");
        for (int i = 0; i < 5; i++) cyc(0, 1, 1, 1, {$urandom, $urandom}, "R6 ignored while held");
        cyc(1, 0, 0, 0, '0, "R1 clear from held");
        // R5 matching check via crossbar load
        cyc(0, 0, 1, 0, {48'h0, GOLD}, "R4 load golden");
        cyc(0, 1, 0, 0, '0, "R5 matching check");
        cyc(0, 0, 0, 0, '0, "R6 match held");
        cyc(0, 0, 0, 1, '1, "R6 match held under valid");
        cyc(1, 1, 1, 1, '1, "R7 clear beats check");
        cyc(0, 0, 0, 0, '0, "R1 accum after clear");
        for (int i = 0; i < 30; i++)
            cyc(0, 0, 0, 1, {$urandom, $urandom}, "R2 second run");
        cyc(0, 1, 0, 0, '0, "R5 check after run");
        cyc(0, 0, 0, 0, '0, "R5 done falls");
        cyc(1, 0, 0, 0, '0, "R1 final clear");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule